// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block supervises the output-frequency selection of a programmable clock generator. Software requests a new 4-bit selection code. When that code differs from the active one and the block is not locked, the new code goes to the output. If supervision is enabled, a countdown starts at that moment. Software confirms that the system came back up by clearing the enable bit before the countdown expires. If it does not, the block forces a fixed recovery code onto the output, sets a sticky status flag and locks out all further selection changes. Only clearing the enable bit releases the lock.

A reset pulse output lets the block restart the system. A pulse can be requested after every accepted selection change, after a time-out, or in both cases. A single control byte, written and read through a plain byte-wide port, holds the enables, the status flag and a stored-only drive-strength flag. The countdown length, the pulse length, the recovery code, the code loaded at reset and the pulse polarity are all parameters.

Top module: `fcwd_top`

## Requirements
- R1: After reset the control byte reads 0x00, `freq_sel` equals the reset code (0 by default) and `sys_rst` is inactive.
- R2: Control byte layout: bit 6 is the drive flag, bit 4 is reset-on-time-out, bit 3 is reset-on-change and bit 1 is the watchdog enable. Each of these reads back the value last written. Bits 7, 5 and 0 always read 0.
- R3: Bit 2 is the time-out status. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R4: A request (`freq_req_vld` high) is accepted only when its code differs from `freq_sel` and the block is not locked. `freq_sel` takes the new code after the clock edge that samples the request. A request carrying the active code changes nothing: no pulse and no countdown.
- R5: Setting the enable alone never starts the countdown; only an accepted change starts it.
- R6: With the enable set, an accepted change sampled at edge E0 causes a time-out at edge E0+CNT_LOAD+1. Status then reads 1, `freq_sel` reads the recovery code and the block is locked.
- R7: Writing 0 to the enable stops the countdown and reloads it. After re-enabling, no time-out happens until a new change occurs, and that change gets the full interval.
- R8: While locked, every selection request is ignored: `freq_sel` stays at the recovery code and no change pulse is produced.
- R9: Writing 0 to the enable releases the lock. A request sampled from the second edge after that write onward is accepted again.
- R10: A time-out produces a reset pulse only when bit 4 is set.
- R11: An accepted change produces a reset pulse when bit 3 is set.
- R12: `sys_rst` is active for PULSE_LEN cycles after the edge that samples a pulse request. A request made during an active pulse restarts the count, so the pulse ends PULSE_LEN cycles after the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| freq_req_vld | input | 1 | Selection request strobe |
| freq_req | input | SEL_W | Requested selection code |
| freq_sel | output | SEL_W | Active selection code |
| sys_rst | output | 1 | Reset pulse (polarity set by parameter) |

## Verification
The countdown is not visible at the ports. An off-by-one in its load or its decrement shows up only when the status bit and the recovery code appear, which is CNT_LOAD+1 cycles after the change. The bench therefore samples one cycle before and one cycle on that edge. A lock flag that is stuck or released too early shows up on the very next ignored or accepted request as a wrong `freq_sel`. A counter that keeps running after the enable is cleared shows up as a spurious time-out within CNT_LOAD cycles of re-enabling. A wrong pulse counter shows up as a `sys_rst` edge one cycle away from PULSE_LEN, or as a pulse that does not stretch when a second request arrives.

// File: rtl/fcwd_pkg.sv
package fcwd_pkg;
   localparam int BIT_DRV = 6;
   localparam int BIT_RTO = 4;
   localparam int BIT_RFC = 3;
   localparam int BIT_STS = 2;
   localparam int BIT_EN  = 1;

   typedef struct packed {
      logic drv;
      logic rst_to;
      logic rst_fc;
      logic sts;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/fcwd_ctrl_reg.sv
module fcwd_ctrl_reg
   import fcwd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       to_fire,
   output ctrl_t      ctrl,
   output logic [7:0] rdata
);
   logic unused_rsvd;
   assign unused_rsvd = ^{wdata[7], wdata[5], wdata[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr) begin
            ctrl.drv    <= wdata[BIT_DRV];
            ctrl.rst_to <= wdata[BIT_RTO];
            ctrl.rst_fc <= wdata[BIT_RFC];
            ctrl.en     <= wdata[BIT_EN];
         end
         // a time-out in the same cycle wins over a clearing write
         if (to_fire)
            ctrl.sts <= 1'b1;
         else if (wr && wdata[BIT_STS])
            ctrl.sts <= 1'b0;
      end
   end

   always_comb begin
      rdata          = '0;
      rdata[BIT_DRV] = ctrl.drv;
      rdata[BIT_RTO] = ctrl.rst_to;
      rdata[BIT_RFC] = ctrl.rst_fc;
      rdata[BIT_STS] = ctrl.sts;
      rdata[BIT_EN]  = ctrl.en;
   end
endmodule

// File: rtl/fcwd_countdown.sv
module fcwd_countdown #(
   parameter int CNT_LOAD = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start,
   output logic to_fire,
   output logic locked
);
   localparam int CW = $clog2(CNT_LOAD + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(CNT_LOAD);

   logic [CW-1:0] cnt;
   logic          running;

   assign to_fire = running && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         running <= 1'b0;
         cnt     <= LOAD_V;
         locked  <= 1'b0;
      end else if (to_fire) begin
         running <= 1'b0;
         cnt     <= LOAD_V;
         locked  <= 1'b1;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= LOAD_V;
      end else if (running) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/fcwd_pulse.sv
module fcwd_pulse #(
   parameter int PULSE_LEN  = 16,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active,
   output logic pulse_out
);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam logic [PW-1:0] LEN_V = PW'(PULSE_LEN);

   logic [PW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left <= '0;
      else if (trig)
         left <= LEN_V;
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign active = (left != '0);

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pulse_out = ~active;
      end else begin : g_high
         assign pulse_out = active;
      end
   endgenerate
endmodule

// File: rtl/fcwd_top.sv
module fcwd_top
   import fcwd_pkg::*;
#(
   parameter int             SEL_W          = 4,
   parameter int             CNT_LOAD       = 1000,
   parameter int             PULSE_LEN      = 16,
   parameter logic [SEL_W-1:0] RECOV_SEL    = SEL_W'(3),
   parameter logic [SEL_W-1:0] RST_SEL      = '0,
   parameter bit             RST_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             freq_req_vld,
   input  logic [SEL_W-1:0] freq_req,
   output logic [SEL_W-1:0] freq_sel,
   output logic             sys_rst
);
   generate
      if (SEL_W < 1) begin : g_bad_w
         $error("SEL_W must be at least 1");
      end
      if (CNT_LOAD < 1) begin : g_bad_load
         $error("CNT_LOAD must be at least 1");
      end
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("PULSE_LEN must be at least 1");
      end
   endgenerate

   ctrl_t ctrl;
   logic  to_fire;
   logic  locked;
   logic  change;
   logic  trig;
   logic  rst_act;

   assign change = freq_req_vld && !locked && !to_fire && (freq_req != freq_sel);
   assign trig   = (change && ctrl.rst_fc) || (to_fire && ctrl.rst_to);

   fcwd_ctrl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .to_fire (to_fire),
      .ctrl    (ctrl),
      .rdata   (reg_rdata)
   );

   fcwd_countdown #(.CNT_LOAD(CNT_LOAD)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.en),
      .start   (change),
      .to_fire (to_fire),
      .locked  (locked)
   );

   fcwd_pulse #(.PULSE_LEN(PULSE_LEN), .ACTIVE_LOW(RST_ACTIVE_LOW)) u_pls (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .active    (rst_act),
      .pulse_out (sys_rst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         freq_sel <= RST_SEL;
      else if (to_fire)
         freq_sel <= RECOV_SEL;
      else if (change)
         freq_sel <= freq_req;
   end
endmodule

// File: rtl/fcwd_chk.sv
module fcwd_chk #(
   parameter int             SEL_W     = 4,
   parameter int             PULSE_LEN = 16,
   parameter logic [SEL_W-1:0] RECOV_SEL = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [7:0]       reg_wdata,
   input logic [7:0]       reg_rdata,
   input logic             freq_req_vld,
   input logic [SEL_W-1:0] freq_sel,
   input logic             locked,
   input logic             rst_act
);
   logic [15:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_cnt <= '0;
      else if (rst_act)
         hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      else
         hi_cnt <= '0;
   end

   // R12
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act) |-> (hi_cnt >= 16'(PULSE_LEN)));

   // R6
   recov_on_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[2]) |-> (freq_sel == RECOV_SEL));

   // R3
   sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[2]) |-> $past(reg_wr && reg_wdata[2]));

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && freq_req_vld) |=> $stable(freq_sel));

   // R4
   sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(freq_req_vld) && !$stable(freq_sel)) |-> (freq_sel == RECOV_SEL));

   // R2
   drv_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata[6] == $past(reg_wdata[6])));
endmodule

bind fcwd_top fcwd_chk #(
   .SEL_W     (SEL_W),
   .PULSE_LEN (PULSE_LEN),
   .RECOV_SEL (RECOV_SEL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .freq_req_vld (freq_req_vld),
   .freq_sel     (freq_sel),
   .locked       (locked),
   .rst_act      (rst_act)
);

// File: tb/fcwd_top_tb.sv
module fcwd_top_tb;
   localparam int         LOAD  = 20;
   localparam int         PLEN  = 16;
   localparam logic [3:0] RECOV = 4'hA;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       freq_req_vld = 1'b0;
   logic [3:0] freq_req = '0;
   logic [3:0] freq_sel;
   logic       sys_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   fcwd_top #(
      .SEL_W(4), .CNT_LOAD(LOAD), .PULSE_LEN(PLEN),
      .RECOV_SEL(RECOV), .RST_SEL(4'h0), .RST_ACTIVE_LOW(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .freq_req_vld(freq_req_vld), .freq_req(freq_req),
      .freq_sel(freq_sel), .sys_rst(sys_rst)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic req_sel(input logic [3:0] c);
      freq_req_vld = 1'b1; freq_req = c;
      @(negedge clk);
      freq_req_vld = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 rdata", 32'(reg_rdata), 32'h00);
      check("R1 freq_sel", 32'(freq_sel), 32'h0);
      check("R1 sys_rst", 32'(sys_rst), 32'h0);
   endtask

   task automatic t_ctrl_fields();
      do_reset();
      wr_ctrl(8'hFF);
      check("R2 all ones", 32'(reg_rdata), 32'h5A);
      wr_ctrl(8'h40);
      check("R2 drv only", 32'(reg_rdata), 32'h40);
      wr_ctrl(8'h00);
      check("R2 cleared", 32'(reg_rdata), 32'h00);
   endtask

   task automatic t_same_code_and_enable();
      do_reset();
      wr_ctrl(8'h0A);           // en + reset-on-change
      step(40);
      check("R5 no timeout from enable", 32'(reg_rdata[2]), 32'h0);
      check("R5 sel kept", 32'(freq_sel), 32'h0);
      req_sel(4'h0);            // same code
      check("R4 same code no pulse", 32'(sys_rst), 32'h0);
      step(30);
      check("R4 same code no countdown", 32'(reg_rdata[2]), 32'h0);
   endtask

   task automatic t_timeout_lock();
      do_reset();
      wr_ctrl(8'h02);
      req_sel(4'h5);
      check("R4 sel updated", 32'(freq_sel), 32'h5);
      step(LOAD);
      check("R6 no early timeout", 32'(reg_rdata[2]), 32'h0);
      check("R6 sel before timeout", 32'(freq_sel), 32'h5);
      step(1);
      check("R6 status set", 32'(reg_rdata[2]), 32'h1);
      check("R6 recovery code", 32'(freq_sel), 32'(RECOV));
      check("R10 no pulse when bit4 clear", 32'(sys_rst), 32'h0);
      req_sel(4'h7);
      check("R8 request ignored", 32'(freq_sel), 32'(RECOV));
      wr_ctrl(8'h00);
      check("R3 write 0 keeps status", 32'(reg_rdata), 32'h04);
      step(1);
      req_sel(4'h7);
      check("R9 unlocked", 32'(freq_sel), 32'h7);
      wr_ctrl(8'h04);
      check("R3 write 1 clears status", 32'(reg_rdata), 32'h00);
   endtask

   task automatic t_stop_reload();
      do_reset();
      wr_ctrl(8'h02);
      req_sel(4'h5);
      step(10);
      wr_ctrl(8'h00);
      wr_ctrl(8'h02);
      step(30);
      check("R7 stopped by disable", 32'(reg_rdata[2]), 32'h0);
      req_sel(4'h6);
      step(LOAD);
      check("R7 full interval", 32'(reg_rdata[2]), 32'h0);
      step(1);
      check("R7 timeout after reload", 32'(reg_rdata[2]), 32'h1);
   endtask

   task automatic t_pulse_on_change();
      do_reset();
      wr_ctrl(8'h08);
      req_sel(4'h3);
      check("R11 pulse starts", 32'(sys_rst), 32'h1);
      step(PLEN - 1);
      check("R12 pulse last cycle", 32'(sys_rst), 32'h1);
      step(1);
      check("R12 pulse ended", 32'(sys_rst), 32'h0);
      req_sel(4'h3);
      check("R4 repeat code no pulse", 32'(sys_rst), 32'h0);
      req_sel(4'h4);
      step(4);
      req_sel(4'h5);
      step(PLEN - 1);
      check("R12 extended pulse high", 32'(sys_rst), 32'h1);
      step(1);
      check("R12 extended pulse ended", 32'(sys_rst), 32'h0);
   endtask

   task automatic t_pulse_on_timeout();
      do_reset();
      wr_ctrl(8'h12);
      req_sel(4'h5);
      check("R11 no change pulse when bit3 clear", 32'(sys_rst), 32'h0);
      step(LOAD);
      check("R10 no pulse before timeout", 32'(sys_rst), 32'h0);
      step(1);
      check("R10 timeout pulse", 32'(sys_rst), 32'h1);
      step(PLEN - 1);
      check("R12 timeout pulse length", 32'(sys_rst), 32'h1);
      step(1);
      check("R12 timeout pulse ended", 32'(sys_rst), 32'h0);
      wr_ctrl(8'h1A);
      req_sel(4'h9);
      check("R8 locked sel", 32'(freq_sel), 32'(RECOV));
      check("R8 locked no pulse", 32'(sys_rst), 32'h0);
   endtask

   initial begin
      step(1);
      t_reset_state();
      t_ctrl_fields();
      t_same_code_and_enable();
      t_timeout_lock();
      t_stop_reload();
      t_pulse_on_change();
      t_pulse_on_timeout();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule